// File: doc/BRIEF.md
# Indirect Control/Status Register Window for a Network Controller

This block is the host-facing register window of a network controller. The host never addresses the internal control/status registers (CSRs) directly. It first writes a register index into an address port, and then reads or writes the chosen CSR through a data port. A second data port reaches the bus configuration registers through the same index. A read of the reset port performs a software reset. Offsets below 0x10 return the station address bytes.

The block holds the main command/status register (CSR0). This register carries the run controls and the interrupt status bits, which the host clears by writing one. A four-state run machine drives the run controls. The states are STOPPED, INITING, READY and RUNNING. The transitions are T_STOP (any state to STOPPED on a write with Stop), T_INIT (any state to INITING on a write with Init), T_START (STOPPED, READY or RUNNING to RUNNING on a write with Strt), and T_DONE (INITING to READY when the init delay counter expires, which also sets the init-done flag). The block also holds the init-block address halves, the mask, feature and promiscuous registers, a read-only chip ID pair and one bus configuration register. It drives a level interrupt output. A mode pin selects the 32-bit or the 16-bit host offset layout.

Top module: `csr_window_port`

## Requirements
- R1: With `wide_mode`=1, offset 0x10 is the CSR data port, 0x14 the address port, 0x18 the reset port and 0x1C the bus-config data port. Any other offset at or above 0x10 reads 0, and writes to it are ignored.
- R2: With `wide_mode`=0, the offsets at or above 0x10 are halved relative to 0x10: data 0x10, address 0x12, reset 0x14, bus-config 0x16. Odd offsets are unmapped, and every read returns 0 in bits 31:16.
- R3: After `rst_n` goes low, and after any read of the reset port (which itself returns 0), the address port reads 0, CSR0 reads 0x0004, and all other registers and outputs return to 0.
- R4: CSR0 bit positions are: Init 0, Strt 1, Stop 2, Tdmd 3, Txon 4, Rxon 5, Iena 6, Intr 7, Idon 8, Tint 9, Rint 10, Merr 11, Miss 12, Cerr 13, Babl 14, Err 15. Init, Strt and Stop read back the run state. Txon and Rxon read 1 only in RUNNING. Within a single write, Stop overrides Init, and Init overrides Strt.
- R5: Writing Init sets Idon exactly INIT_CYCLES clock edges after the edge that takes the write. Init reads 1 while initialisation is in progress, and a Strt write during that time is ignored.
- R6: Writing 1 to Tint, Rint, Merr, Miss, Cerr or Babl clears that bit, and writing 0 leaves it unchanged. An event arriving in the same cycle as its clear leaves the bit set. Iena takes the written value on every CSR0 write.
- R7: Err (bit 15) reads as the OR of Babl, Cerr, Miss and Merr.
- R8: Intr and `irq` equal Iena AND (Tint OR Rint OR Merr OR Miss OR Cerr OR Babl OR (Idon AND NOT CSR3 bit 8)).
- R9: A CSR0 write with Tdmd set in RUNNING gives a one-cycle `tx_poll` pulse after the write edge. The same write in any other state gives no pulse. Tdmd always reads 0.
- R10: CSR1, CSR2, CSR3, CSR4 and CSR15 are 16-bit read/write registers. `init_blk_addr` is {CSR2, CSR1}, `tx_autopad` is CSR4 bit 11, and `promisc` is CSR15 bit 15. All other CSR indices except 0, 88 and 89 read 0.
- R11: CSR88 reads CHIP_ID[15:0] and CSR89 reads CHIP_ID[31:16]. Writes to them have no effect.
- R12: Bus-config register 20 is a 16-bit read/write register reached through the bus-config port. `sw_style32` is 1 when its value is 0x0002. Other bus-config indices read 0.
- R13: An offset below 0x10 returns station address bytes in little-endian order, starting at that byte offset. Byte k is STATION_MAC[47-8k -: 8] for k<6, and bytes 6 to 15 are 0. In 16-bit mode only two bytes are returned.
- R14: `host_rvalid` and `host_rdata` are valid in the cycle after the edge that takes `host_rd`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wide_mode | input | 1 | 1: 32-bit offset layout, 0: 16-bit layout |
| host_rd | input | 1 | Read strobe |
| host_wr | input | 1 | Write strobe |
| host_addr | input | ADDR_W | Byte offset within the window |
| host_wdata | input | 32 | Write data |
| host_rdata | output | 32 | Read data, registered |
| host_rvalid | output | 1 | Read data valid |
| ev_tint | input | 1 | Transmit-done event pulse |
| ev_rint | input | 1 | Receive-done event pulse |
| ev_merr | input | 1 | Memory error event pulse |
| ev_miss | input | 1 | Missed frame event pulse |
| ev_cerr | input | 1 | Collision error event pulse |
| ev_babl | input | 1 | Transmit timeout event pulse |
| irq | output | 1 | Interrupt request (level) |
| tx_poll | output | 1 | Transmit poll pulse |
| promisc | output | 1 | Promiscuous mode enable |
| tx_autopad | output | 1 | Transmit auto-pad enable |
| sw_style32 | output | 1 | 32-bit software style selected |
| init_blk_addr | output | 32 | Initialisation block address |

## Verification
The bench uses the default INIT_CYCLES of 8 and the default CHIP_ID. This lets it count the exact edge at which Idon appears on `irq`, and compare the ID halves against fixed values. STATION_MAC is set to 48'h02_11_22_33_44_55, so that every byte lane of the station readout is distinct in both layouts. The bench also switches `wide_mode` during the run, so the same registers are reached through both offset maps.

// File: rtl/csr_port_pkg.sv
package csr_port_pkg;

    typedef enum logic [1:0] {
        ST_STOPPED = 2'd0,
        ST_INITING = 2'd1,
        ST_READY   = 2'd2,
        ST_RUNNING = 2'd3
    } run_state_t;

    typedef enum logic [2:0] {
        PT_NONE    = 3'd0,
        PT_STATION = 3'd1,
        PT_DATA    = 3'd2,
        PT_ADDR    = 3'd3,
        PT_RESET   = 3'd4,
        PT_BUS     = 3'd5
    } port_t;

    // CSR0 bit positions (software depends on them)
    localparam int B_INIT = 0;
    localparam int B_STRT = 1;
    localparam int B_STOP = 2;
    localparam int B_TDMD = 3;
    localparam int B_TXON = 4;
    localparam int B_RXON = 5;
    localparam int B_IENA = 6;
    localparam int B_INTR = 7;
    localparam int B_IDON = 8;
    localparam int B_TINT = 9;
    localparam int B_RINT = 10;
    localparam int B_MERR = 11;
    localparam int B_MISS = 12;
    localparam int B_CERR = 13;
    localparam int B_BABL = 14;
    localparam int B_ERR  = 15;

    localparam int HOST_W = 32;
    localparam int REG_W  = 16;
    localparam int N_EVT  = 6;

endpackage

// File: rtl/csr_port_decode.sv
module csr_port_decode
    import csr_port_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int BASE   = 16
) (
    input  logic              wide_mode,
    input  logic [ADDR_W-1:0] addr,
    output port_t             port
);
    localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(BASE);

    logic [ADDR_W-1:0] rel;
    logic [ADDR_W-1:0] idx;
    logic              aligned;

    always_comb begin
        rel     = addr - BASE_A;
        aligned = wide_mode ? (rel[1:0] == 2'b00) : (rel[0] == 1'b0);
        idx     = wide_mode ? (rel >> 2) : (rel >> 1);
        port    = PT_NONE;
        if (addr < BASE_A) begin
            port = PT_STATION;
        end else if (aligned) begin
            unique case (idx)
                ADDR_W'(0): port = PT_DATA;
                ADDR_W'(1): port = PT_ADDR;
                ADDR_W'(2): port = PT_RESET;
                ADDR_W'(3): port = PT_BUS;
                default:    port = PT_NONE;
            endcase
        end
    end
endmodule

// File: rtl/csr_port_station.sv
module csr_port_station #(
    parameter logic [47:0] STATION_MAC = 48'h0
) (
    input  logic [3:0]  offs,
    output logic [31:0] word
);
    localparam int N_BYTES = 6;

    function automatic logic [7:0] byte_at(input int b);
        if (b < N_BYTES) return STATION_MAC[47-8*b -: 8];
        return 8'h00;
    endfunction

    always_comb begin
        word = '0;
        for (int k = 0; k < 4; k++) begin
            word[8*k +: 8] = byte_at(int'(offs) + k);
        end
    end
endmodule

// File: rtl/csr_port_ctrl.sv
module csr_port_ctrl
    import csr_port_pkg::*;
#(
    parameter int INIT_CYCLES = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             srst,
    input  logic             wr,
    input  logic [REG_W-1:0] wdata,
    input  logic             idon_mask,
    input  logic [N_EVT-1:0] evt,      // 0 tint,1 rint,2 merr,3 miss,4 cerr,5 babl
    output logic [REG_W-1:0] csr0,
    output logic             irq,
    output logic             tx_poll
);
    localparam int CNT_W = $clog2(INIT_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(INIT_CYCLES - 1);

    run_state_t       state, nxt;
    logic [CNT_W-1:0] cnt;
    logic [N_EVT-1:0] sts;
    logic [N_EVT-1:0] clr;
    logic             idon, iena;
    logic             go_stop, go_init, go_strt, done;
    logic             err, intr;
    logic             unused_ro;

    assign unused_ro = ^{wdata[15], wdata[8:7], wdata[5:4]};

    // next-state logic
    always_comb begin
        go_stop = wr && wdata[B_STOP];
        go_init = wr && wdata[B_INIT] && !go_stop;
        go_strt = wr && wdata[B_STRT] && !go_stop && !go_init && (state != ST_INITING);
        nxt     = state;
        unique case (state)
            ST_STOPPED: nxt = state;
            ST_INITING: if (cnt == '0) nxt = ST_READY;
            ST_READY:   nxt = state;
            ST_RUNNING: nxt = state;
        endcase
        if (go_stop)      nxt = ST_STOPPED;
        else if (go_init) nxt = ST_INITING;
        else if (go_strt) nxt = ST_RUNNING;
        done = (state == ST_INITING) && (nxt == ST_READY);
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n || srst) state <= ST_STOPPED;
        else                state <= nxt;
    end

    always_comb begin
        clr = '0;
        if (wr) clr = {wdata[B_BABL], wdata[B_CERR], wdata[B_MISS],
                       wdata[B_MERR], wdata[B_RINT], wdata[B_TINT]};
    end

    // status, counter and pulse registers
    always_ff @(posedge clk) begin
        if (!rst_n || srst) begin
            cnt     <= '0;
            sts     <= '0;
            idon    <= 1'b0;
            iena    <= 1'b0;
            tx_poll <= 1'b0;
        end else begin
            if (go_init)                             cnt <= CNT_LOAD;
            else if (state == ST_INITING && cnt != '0) cnt <= cnt - 1'b1;
            sts <= (sts & ~clr) | evt;
            if (go_stop || go_init) idon <= 1'b0;
            else if (done)          idon <= 1'b1;
            if (wr) iena <= wdata[B_IENA];
            tx_poll <= wr && wdata[B_TDMD] && (state == ST_RUNNING) && (nxt == ST_RUNNING);
        end
    end

    // output assembly
    always_comb begin
        err  = sts[5] | sts[4] | sts[3] | sts[2];
        intr = iena && ((|sts) || (idon && !idon_mask));
        csr0         = '0;
        csr0[B_INIT] = (state == ST_INITING);
        csr0[B_STRT] = (state == ST_RUNNING);
        csr0[B_STOP] = (state == ST_STOPPED);
        csr0[B_TXON] = (state == ST_RUNNING);
        csr0[B_RXON] = (state == ST_RUNNING);
        csr0[B_IENA] = iena;
        csr0[B_INTR] = intr;
        csr0[B_IDON] = idon;
        csr0[B_TINT] = sts[0];
        csr0[B_RINT] = sts[1];
        csr0[B_MERR] = sts[2];
        csr0[B_MISS] = sts[3];
        csr0[B_CERR] = sts[4];
        csr0[B_BABL] = sts[5];
        csr0[B_ERR]  = err;
        irq          = intr;
    end

    assert_softreset_R3: assert property (@(posedge clk) disable iff (!rst_n)
        srst |=> (csr0 == 16'h0004));
    assert_w1c_rint_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && wdata[B_RINT] && !evt[1] && !srst) |=> !csr0[B_RINT]);
    assert_stop_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && wdata[B_STOP]) |=> (csr0[B_STOP] && !csr0[B_STRT] && !csr0[B_TXON] && !csr0[B_RXON]));
    assert_runbits_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(csr0[2:0]));
    assert_idon_src_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(csr0[B_IDON]) |-> ($past(state) == ST_INITING));
    assert_irq_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> csr0[B_IENA]);
    assert_poll_run_R9: assert property (@(posedge clk) disable iff (!rst_n)
        tx_poll |-> $past(state == ST_RUNNING));
endmodule

// File: rtl/csr_window_port.sv
module csr_window_port
    import csr_port_pkg::*;
#(
    parameter int          ADDR_W      = 5,
    parameter int          RAP_W       = 8,
    parameter int          INIT_CYCLES = 8,
    parameter logic [31:0] CHIP_ID     = 32'h0242_0003,
    parameter logic [47:0] STATION_MAC = 48'h02_11_22_33_44_55
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wide_mode,
    input  logic              host_rd,
    input  logic              host_wr,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [31:0]       host_wdata,
    output logic [31:0]       host_rdata,
    output logic              host_rvalid,
    input  logic              ev_tint,
    input  logic              ev_rint,
    input  logic              ev_merr,
    input  logic              ev_miss,
    input  logic              ev_cerr,
    input  logic              ev_babl,
    output logic              irq,
    output logic              tx_poll,
    output logic              promisc,
    output logic              tx_autopad,
    output logic              sw_style32,
    output logic [31:0]       init_blk_addr
);
    localparam logic [RAP_W-1:0] IX_CSR0   = RAP_W'(0);
    localparam logic [RAP_W-1:0] IX_IBLO   = RAP_W'(1);
    localparam logic [RAP_W-1:0] IX_IBHI   = RAP_W'(2);
    localparam logic [RAP_W-1:0] IX_MASK   = RAP_W'(3);
    localparam logic [RAP_W-1:0] IX_FEAT   = RAP_W'(4);
    localparam logic [RAP_W-1:0] IX_MODE   = RAP_W'(15);
    localparam logic [RAP_W-1:0] IX_IDLO   = RAP_W'(88);
    localparam logic [RAP_W-1:0] IX_IDHI   = RAP_W'(89);
    localparam logic [RAP_W-1:0] IX_STYLE  = RAP_W'(20);
    localparam int IDON_MASK_BIT = 8;
    localparam int AUTOPAD_BIT   = 11;
    localparam int PROMISC_BIT   = 15;

    port_t            port;
    logic [RAP_W-1:0] rap;
    logic [REG_W-1:0] csr_iblo, csr_ibhi, csr_mask, csr_feat, csr_mode, bcr_style;
    logic [REG_W-1:0] csr0, csr_rd, bcr_rd;
    logic [31:0]      st_word, rd_word;
    logic             srst, wr_data, wr_addr, wr_bus;
    logic [REG_W-1:0] wd;
    logic             unused_hi;

    assign wd        = host_wdata[REG_W-1:0];
    assign unused_hi = ^host_wdata[31:REG_W];

    csr_port_decode #(.ADDR_W(ADDR_W), .BASE(16)) u_decode (
        .wide_mode (wide_mode),
        .addr      (host_addr),
        .port      (port)
    );

    csr_port_station #(.STATION_MAC(STATION_MAC)) u_station (
        .offs (host_addr[3:0]),
        .word (st_word)
    );

    assign srst    = host_rd && (port == PT_RESET);
    assign wr_data = host_wr && (port == PT_DATA);
    assign wr_addr = host_wr && (port == PT_ADDR);
    assign wr_bus  = host_wr && (port == PT_BUS);

    csr_port_ctrl #(.INIT_CYCLES(INIT_CYCLES)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .srst      (srst),
        .wr        (wr_data && (rap == IX_CSR0)),
        .wdata     (wd),
        .idon_mask (csr_mask[IDON_MASK_BIT]),
        .evt       ({ev_babl, ev_cerr, ev_miss, ev_merr, ev_rint, ev_tint}),
        .csr0      (csr0),
        .irq       (irq),
        .tx_poll   (tx_poll)
    );

    always_ff @(posedge clk) begin
        if (!rst_n || srst) begin
            rap       <= '0;
            csr_iblo  <= '0;
            csr_ibhi  <= '0;
            csr_mask  <= '0;
            csr_feat  <= '0;
            csr_mode  <= '0;
            bcr_style <= '0;
        end else begin
            if (wr_addr) rap <= host_wdata[RAP_W-1:0];
            if (wr_data) begin
                if (rap == IX_IBLO) csr_iblo <= wd;
                if (rap == IX_IBHI) csr_ibhi <= wd;
                if (rap == IX_MASK) csr_mask <= wd;
                if (rap == IX_FEAT) csr_feat <= wd;
                if (rap == IX_MODE) csr_mode <= wd;
            end
            if (wr_bus && rap == IX_STYLE) bcr_style <= wd;
        end
    end

    always_comb begin
        csr_rd = '0;
        if      (rap == IX_CSR0) csr_rd = csr0;
        else if (rap == IX_IBLO) csr_rd = csr_iblo;
        else if (rap == IX_IBHI) csr_rd = csr_ibhi;
        else if (rap == IX_MASK) csr_rd = csr_mask;
        else if (rap == IX_FEAT) csr_rd = csr_feat;
        else if (rap == IX_MODE) csr_rd = csr_mode;
        else if (rap == IX_IDLO) csr_rd = CHIP_ID[15:0];
        else if (rap == IX_IDHI) csr_rd = CHIP_ID[31:16];
        bcr_rd = (rap == IX_STYLE) ? bcr_style : '0;
        rd_word = '0;
        unique case (port)
            PT_STATION: rd_word = st_word;
            PT_DATA:    rd_word = {{(32-REG_W){1'b0}}, csr_rd};
            PT_ADDR:    rd_word = {{(32-RAP_W){1'b0}}, rap};
            PT_BUS:     rd_word = {{(32-REG_W){1'b0}}, bcr_rd};
            PT_RESET:   rd_word = '0;
            PT_NONE:    rd_word = '0;
            default:    rd_word = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            host_rvalid <= 1'b0;
            host_rdata  <= '0;
        end else begin
            host_rvalid <= host_rd;
            if (host_rd) host_rdata <= wide_mode ? rd_word : {16'h0, rd_word[15:0]};
        end
    end

    assign promisc       = csr_mode[PROMISC_BIT];
    assign tx_autopad    = csr_feat[AUTOPAD_BIT];
    assign sw_style32    = (bcr_style == 16'h0002);
    assign init_blk_addr = {csr_ibhi, csr_iblo};

    assert_rd_latency_R14: assert property (@(posedge clk) disable iff (!rst_n)
        host_rd |=> host_rvalid);
    assert_narrow_upper_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && !wide_mode) |=> (host_rdata[31:16] == 16'h0));
    assert_reset_port_R3: assert property (@(posedge clk) disable iff (!rst_n)
        srst |=> (rap == '0 && !promisc && !tx_autopad && init_blk_addr == 32'h0));
endmodule

// File: tb/csr_window_port_tb.sv
module csr_window_port_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wide_mode = 1'b1;
    logic        host_rd = 1'b0, host_wr = 1'b0;
    logic [4:0]  host_addr = '0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic        host_rvalid;
    logic        ev_tint = 0, ev_rint = 0, ev_merr = 0, ev_miss = 0, ev_cerr = 0, ev_babl = 0;
    logic        irq, tx_poll, promisc, tx_autopad, sw_style32;
    logic [31:0] init_blk_addr;

    int total = 0;
    int bad = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    csr_window_port #(.STATION_MAC(48'h02_11_22_33_44_55)) dut_i (
        .clk(clk), .rst_n(rst_n), .wide_mode(wide_mode),
        .host_rd(host_rd), .host_wr(host_wr), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .host_rvalid(host_rvalid),
        .ev_tint(ev_tint), .ev_rint(ev_rint), .ev_merr(ev_merr),
        .ev_miss(ev_miss), .ev_cerr(ev_cerr), .ev_babl(ev_babl),
        .irq(irq), .tx_poll(tx_poll), .promisc(promisc), .tx_autopad(tx_autopad),
        .sw_style32(sw_style32), .init_blk_addr(init_blk_addr)
    );

    function automatic logic [4:0] a_data(); return 5'h10; endfunction
    function automatic logic [4:0] a_addr(); return wide_mode ? 5'h14 : 5'h12; endfunction
    function automatic logic [4:0] a_rst();  return wide_mode ? 5'h18 : 5'h14; endfunction
    function automatic logic [4:0] a_bus();  return wide_mode ? 5'h1C : 5'h16; endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        host_wr = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    // driver: push expectation, then issue the read
    task automatic rd(input logic [4:0] a, input logic [31:0] exp, input string tag);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        @(negedge clk);
        host_rd = 1'b1; host_addr = a;
        @(negedge clk);
        host_rd = 1'b0;
    endtask

    task automatic csr_wr(input int idx, input logic [31:0] d);
        wr(a_addr(), 32'(idx));
        wr(a_data(), d);
    endtask

    task automatic csr_rd(input int idx, input logic [31:0] exp, input string tag);
        wr(a_addr(), 32'(idx));
        rd(a_data(), exp, tag);
    endtask

    task automatic pulse(input logic [5:0] m);  // babl,cerr,miss,merr,rint,tint
        @(negedge clk);
        {ev_babl, ev_cerr, ev_miss, ev_merr, ev_rint, ev_tint} = m;
        @(negedge clk);
        {ev_babl, ev_cerr, ev_miss, ev_merr, ev_rint, ev_tint} = '0;
    endtask

    // monitor: compare each returned read with the queued expectation
    always @(negedge clk) begin
        if (host_rvalid) begin
            if (exp_q.size() == 0) begin
                total++; bad++;
                $display("FAIL R14 unexpected rvalid actual=0x%08h expected=none", host_rdata);
            end else begin
                chk(tag_q.pop_front(), host_rdata, exp_q.pop_front());
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 100000);
        total++; bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk("R3 irq after reset", 32'(irq), 0);
        chk("R3 promisc after reset", 32'(promisc), 0);
        rd(5'h14, 32'h0, "R3 address port after reset");
        rd(5'h10, 32'h0004, "R3 R4 csr0 reset value");

        // station address, 32-bit layout
        rd(5'h00, 32'h3322_1102, "R13 station bytes 0-3");
        rd(5'h04, 32'h0000_5544, "R13 station bytes 4-5");
        rd(5'h0C, 32'h0, "R13 station beyond address");
        rd(5'h11, 32'h0, "R1 misaligned offset");
        rd(5'h1A, 32'h0, "R1 unmapped offset");

        // chip id
        csr_rd(88, 32'h0003, "R11 id low");
        csr_rd(89, 32'h0242, "R11 id high");
        csr_wr(88, 32'hFFFF);
        csr_rd(88, 32'h0003, "R11 id write ignored");

        // plain registers
        csr_wr(1, 32'h1234);
        csr_wr(2, 32'hABCD);
        chk("R10 init block address", init_blk_addr, 32'hABCD_1234);
        csr_wr(4, 32'h0800);
        chk("R10 autopad", 32'(tx_autopad), 1);
        csr_wr(15, 32'h8000);
        chk("R10 promisc", 32'(promisc), 1);
        csr_rd(15, 32'h8000, "R10 csr15 readback");
        csr_rd(7, 32'h0, "R10 unused index");

        // bus-config register
        wr(a_addr(), 20);
        wr(a_bus(), 32'h0002);
        chk("R12 style select", 32'(sw_style32), 1);
        rd(a_bus(), 32'h0002, "R12 bcr20 readback");
        wr(a_addr(), 21);
        rd(a_bus(), 32'h0, "R12 other bcr");

        // initialisation timing
        wr(a_addr(), 0);
        wr(a_data(), 32'h0040);
        chk("R8 iena no source", 32'(irq), 0);
        wr(a_data(), 32'h0041);
        repeat (7) @(negedge clk);
        chk("R5 idon not yet", 32'(irq), 0);
        @(negedge clk);
        chk("R5 R8 idon raises irq", 32'(irq), 1);
        rd(a_data(), 32'h01C0, "R5 csr0 ready");

        csr_wr(3, 32'h0100);
        chk("R8 idon masked", 32'(irq), 0);
        wr(a_addr(), 0);
        rd(a_data(), 32'h0140, "R8 csr0 masked");

        // start and transmit poll
        wr(a_data(), 32'h0042);
        rd(a_data(), 32'h0172, "R4 running");
        wr(a_data(), 32'h0048);
        chk("R9 poll pulse", 32'(tx_poll), 1);
        @(negedge clk);
        chk("R9 poll one cycle", 32'(tx_poll), 0);
        rd(a_data(), 32'h0172, "R9 tdmd reads zero");

        // status bits
        pulse(6'b001010);
        rd(a_data(), 32'h95F2, "R7 err summary");
        chk("R8 irq on status", 32'(irq), 1);
        wr(a_data(), 32'h0440);
        rd(a_data(), 32'h91F2, "R6 clear rint only");
        wr(a_data(), 32'h1040);
        rd(a_data(), 32'h0172, "R6 clear miss");
        chk("R8 irq cleared", 32'(irq), 0);

        @(negedge clk);
        host_wr = 1'b1; host_addr = a_data(); host_wdata = 32'h0240; ev_tint = 1'b1;
        @(negedge clk);
        host_wr = 1'b0; ev_tint = 1'b0;
        rd(a_data(), 32'h03F2, "R6 event beats clear");
        wr(a_data(), 32'h0240);

        pulse(6'b010000);
        wr(a_data(), 32'h0000);
        rd(a_data(), 32'hA132, "R8 iena cleared");
        chk("R8 irq gated by iena", 32'(irq), 0);

        // stop and priorities
        wr(a_data(), 32'h2004);
        rd(a_data(), 32'h0004, "R4 stopped");
        wr(a_data(), 32'h0008);
        chk("R9 no poll when stopped", 32'(tx_poll), 0);
        wr(a_data(), 32'h0007);
        rd(a_data(), 32'h0004, "R4 stop beats init and strt");
        wr(a_data(), 32'h0003);
        rd(a_data(), 32'h0001, "R4 init beats strt");
        wr(a_data(), 32'h0002);
        rd(a_data(), 32'h0001, "R5 strt ignored while initing");
        repeat (10) @(negedge clk);
        rd(a_data(), 32'h0100, "R5 ready after init");

        // software reset
        rd(a_rst(), 32'h0, "R3 reset port reads zero");
        chk("R3 promisc cleared", 32'(promisc), 0);
        chk("R3 autopad cleared", 32'(tx_autopad), 0);
        chk("R3 init address cleared", init_blk_addr, 32'h0);
        rd(5'h10, 32'h0004, "R3 csr0 after soft reset");
        rd(5'h14, 32'h0, "R3 rap after soft reset");

        // 16-bit layout
        @(negedge clk);
        wide_mode = 1'b0;
        rd(5'h00, 32'h1102, "R2 R13 narrow station low");
        rd(5'h02, 32'h3322, "R2 R13 narrow station mid");
        wr(5'h12, 15);
        wr(5'h10, 32'h8000);
        chk("R2 promisc via narrow", 32'(promisc), 1);
        rd(5'h10, 32'h8000, "R2 narrow data port");
        rd(5'h12, 32'h000F, "R2 narrow address port");
        wr(5'h12, 89);
        rd(5'h10, 32'h0242, "R2 narrow id high");
        wr(5'h12, 20);
        wr(5'h16, 32'h0002);
        rd(5'h16, 32'h0002, "R2 narrow bus port");
        rd(5'h14, 32'h0, "R2 narrow reset port");
        chk("R2 narrow reset clears promisc", 32'(promisc), 0);
        rd(5'h10, 32'h0004, "R2 csr0 after narrow reset");
        rd(5'h11, 32'h0, "R2 odd offset unmapped");

        repeat (3) @(negedge clk);
        chk("R14 all reads returned", 32'(exp_q.size()), 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule